// File: doc/BRIEF.md
# Serial NAND Page Read Controller

This block reads single bytes from a serial NAND device over a one-lane SPI link, in mode 0 with the most significant bit first. The host asks for a byte by giving a page number and an 11-bit column inside a 2 KB page. The block keeps track of which page sits in the device's internal cache. If the host asks for that page again, the block only runs a cache-read frame. If the host asks for any other page, the block first loads that page into the cache. It then keeps polling the device's status register until the load is finished, and it records the ECC outcome before it reads the byte.

The device stays busy for an unknown time during a load, typically tens of microseconds. For that reason the block decides after every status frame whether to poll again or to go on; it does not wait for a fixed number of cycles. A poll limit set by a parameter stops a device that never comes out of busy. When the limit is reached the block reports a timeout and returns to idle.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, `ready` is high, `spi_cs_n` is high, `spi_sck` is low, `rsp_valid` is low, `ecc_code` is 0 and `ecc_fatal` is 0, and no page counts as loaded.
- R2: A request for a page other than the loaded one begins with a load frame. The frame is opcode 0x13 followed by the page number zero-extended to 24 bits and sent in three bytes, most significant byte first. Every frame is one low period of `spi_cs_n`, and `spi_sck` stays low whenever `spi_cs_n` is high.
- R3: After the load frame, the block sends status frames. Each status frame is 0x0F, then 0xC0, then one byte read back from the device. Bit 0 of the returned byte means busy. The block repeats status frames while that bit is 1 and issues no cache read before it reads a status byte with bit 0 clear.
- R4: Bits 5:4 of the first non-busy status byte are placed on `ecc_code` (0 = clean, 1 = corrected, 2 = uncorrectable). A value of 2 sets `ecc_fatal`, which stays set until reset. The page still counts as loaded afterwards.
- R5: A cache-read frame is 0x03, then the column zero-extended to 16 bits (high byte first), then one dummy byte, then one data byte. That data byte appears on `rsp_data` together with a one-cycle `rsp_valid` pulse, with `rsp_timeout` low.
- R6: A request for the page that is already loaded produces only a cache-read frame, with no load frame and no status frame.
- R7: A request for a different page always runs the full sequence again: load, status polls until not busy, then cache read.
- R8: If `MAX_POLLS` status frames in a row all return busy, the block pulses `rsp_valid` with `rsp_timeout` high and issues no cache read. No page then counts as loaded, so the next request reloads.
- R9: A `req` that arrives while `ready` is low is ignored. It causes no frame, either during the current transaction or after it.
- R10: Columns 0x000 and 0x7FF, the two ends of the 2 KB window, are both read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request, accepted only while `ready` is high |
| req_page | input | PAGE_W | Page number of the request |
| req_col | input | 11 | Byte column inside the 2 KB page |
| ready | output | 1 | Idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle pulse marking the end of a request |
| rsp_data | output | 8 | Byte read from the device |
| rsp_timeout | output | 1 | Set with `rsp_valid` when polling gave up |
| ecc_code | output | 2 | ECC result of the most recent page load |
| ecc_fatal | output | 1 | Sticky flag for an uncorrectable page load |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
On every cycle the assertions check the following: the serial clock stays quiet whenever chip select is high; no byte transfer starts while another is still shifting; the poll counter never passes its limit; a data response only ever comes from a page marked loaded; a timeout always leaves no page marked loaded; and the fatal ECC flag never drops. Three properties need a device model that sees whole frames, so only the bench scenarios can show them. These are the exact opcodes and address bytes on the wire, that no cache read is issued while the device is still busy, and that a hit skips both the load and the status frames. The scenarios also cover a timeout followed by a reload, a sticky uncorrectable result, and a request that is ignored while the block is busy.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

    localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
    localparam logic [7:0] OP_GET_REG   = 8'h0F;
    localparam logic [7:0] OP_CACHE_RD  = 8'h03;
    localparam logic [7:0] REG_STAT     = 8'hC0;
    localparam int         COL_W        = 11;
    localparam int         BUSY_BIT     = 0;
    localparam int         ECC_LO       = 4;
    localparam logic [1:0] ECC_UNFIXED  = 2'd2;

    typedef enum logic [1:0] {FR_LOAD, FR_POLL, FR_READ} frame_t;
    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP} state_t;

    function automatic logic [2:0] frame_len(frame_t f);
        case (f)
            FR_LOAD: return 3'd4;
            FR_POLL: return 3'd3;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(frame_t f, logic [2:0] idx,
                                              logic [23:0] row, logic [15:0] col);
        case (f)
            FR_LOAD: case (idx)
                3'd0:    return OP_PAGE_LOAD;
                3'd1:    return row[23:16];
                3'd2:    return row[15:8];
                default: return row[7:0];
            endcase
            FR_POLL: case (idx)
                3'd0:    return OP_GET_REG;
                3'd1:    return REG_STAT;
                default: return 8'h00;
            endcase
            default: case (idx)
                3'd0:    return OP_CACHE_RD;
                3'd1:    return col[15:8];
                3'd2:    return col[7:0];
                default: return 8'h00;
            endcase
        endcase
    endfunction

endpackage

// File: rtl/nand_spi_byte.sv
module nand_spi_byte (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);
    logic [7:0] sh;
    logic [2:0] cnt;
    logic       ph;
    logic       act;

    assign mosi = sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0; cnt <= '0; ph <= 1'b0; act <= 1'b0;
            sck <= 1'b0; done <= 1'b0; rx <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh  <= tx;
                cnt <= '0;
                ph  <= 1'b0;
                act <= 1'b1;
                sck <= 1'b0;
            end else if (act) begin
                if (!ph) begin
                    sck <= 1'b1;
                    rx  <= {rx[6:0], miso};
                    ph  <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    ph  <= 1'b0;
                    if (cnt == 3'd7) begin
                        act  <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + 3'd1;
                        sh  <= {sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R2: a new byte is only launched once the previous one has finished
    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !act);

endmodule

// File: rtl/nand_page_tag.sv
module nand_page_tag #(
    parameter int PAGE_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [PAGE_W-1:0] look_page,
    output logic              hit,
    output logic              valid
);
    logic [PAGE_W-1:0] tag;

    assign hit = valid && (tag == look_page);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag   <= '0;
        end else if (inval) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            tag   <= load_page;
        end
    end

    // R7: a reload start and a load completion never coincide
    a_r7_inval_load_apart: assert property (@(posedge clk) disable iff (rst)
        !(inval && load));

endmodule

// File: rtl/nand_poll_ctr.sv
module nand_poll_ctr #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT) + 1;
    logic [CW-1:0] cnt;

    assign at_limit = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    // R8: the busy-poll count stays below the limit
    a_r8_poll_cap: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));
    a_r8_no_inc_at_cap: assert property (@(posedge clk) disable iff (rst)
        !(inc && at_limit));

endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_rd_pkg::*;
#(
    parameter int PAGE_W    = 17,
    parameter int MAX_POLLS = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [COL_W-1:0]  req_col,
    output logic              ready,
    output logic              rsp_valid,
    output logic [7:0]        rsp_data,
    output logic              rsp_timeout,
    output logic [1:0]        ecc_code,
    output logic              ecc_fatal,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    state_t            state;
    frame_t            kind;
    logic [2:0]        idx;
    logic              kick;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic [7:0]        last_rx;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              hit, tag_valid, at_limit;
    logic              tag_inval, tag_load, poll_clr, poll_inc, dev_busy;

    assign ready    = (state == ST_IDLE);
    assign spi_cs_n = (state != ST_XFER);
    assign dev_busy = last_rx[BUSY_BIT];

    assign tag_inval = ready && req && !hit;
    assign tag_load  = (state == ST_GAP) && (kind == FR_POLL) && !dev_busy;
    assign poll_clr  = (state == ST_GAP) && (kind == FR_LOAD);
    assign poll_inc  = (state == ST_GAP) && (kind == FR_POLL) && dev_busy && !at_limit;

    nand_spi_byte u_shift (
        .clk(clk), .rst(rst), .start(kick),
        .tx(frame_byte(kind, idx, 24'(page_q), 16'(col_q))),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .done(sh_done), .rx(sh_rx)
    );

    nand_page_tag #(.PAGE_W(PAGE_W)) u_tag (
        .clk(clk), .rst(rst), .inval(tag_inval), .load(tag_load),
        .load_page(page_q), .look_page(req_page), .hit(hit), .valid(tag_valid)
    );

    nand_poll_ctr #(.LIMIT(MAX_POLLS)) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .at_limit(at_limit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE; kind <= FR_LOAD; idx <= '0; kick <= 1'b0;
            page_q <= '0; col_q <= '0; last_rx <= '0;
            rsp_valid <= 1'b0; rsp_data <= '0; rsp_timeout <= 1'b0;
            ecc_code <= '0; ecc_fatal <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            kick      <= 1'b0;
            case (state)
                ST_IDLE: if (req) begin
                    page_q      <= req_page;
                    col_q       <= req_col;
                    kind        <= hit ? FR_READ : FR_LOAD;
                    idx         <= '0;
                    kick        <= 1'b1;
                    rsp_timeout <= 1'b0;
                    state       <= ST_XFER;
                end
                ST_XFER: if (sh_done) begin
                    if (idx == frame_len(kind) - 3'd1) begin
                        last_rx <= sh_rx;
                        state   <= ST_GAP;
                    end else begin
                        idx  <= idx + 3'd1;
                        kick <= 1'b1;
                    end
                end
                default: begin
                    idx <= '0;
                    case (kind)
                        FR_LOAD: begin
                            kind <= FR_POLL; kick <= 1'b1; state <= ST_XFER;
                        end
                        FR_POLL: begin
                            if (dev_busy && at_limit) begin
                                rsp_valid   <= 1'b1;
                                rsp_timeout <= 1'b1;
                                state       <= ST_IDLE;
                            end else if (dev_busy) begin
                                kick <= 1'b1; state <= ST_XFER;
                            end else begin
                                ecc_code <= last_rx[ECC_LO+1:ECC_LO];
                                if (last_rx[ECC_LO+1:ECC_LO] == ECC_UNFIXED)
                                    ecc_fatal <= 1'b1;
                                kind <= FR_READ; kick <= 1'b1; state <= ST_XFER;
                            end
                        end
                        default: begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= last_rx;
                            state     <= ST_IDLE;
                        end
                    endcase
                end
            endcase
        end
    end

    // R2: clock is quiet while the device is deselected
    a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);
    // R5: data responses only come from a loaded page
    a_r5_data_from_loaded: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_timeout) |-> tag_valid);
    // R8: a timeout leaves nothing marked loaded
    a_r8_timeout_unloads: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_timeout) |-> !tag_valid);
    // R4: the uncorrectable flag is sticky
    a_r4_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
        ecc_fatal |=> ecc_fatal);
    // R9: a busy block holds its captured request
    a_r9_busy_holds_req: assert property (@(posedge clk) disable iff (rst)
        (!ready && !$past(ready)) |-> $stable(page_q));

endmodule

// File: tb/nand_page_reader_test.sv
module nand_page_reader_test;
    localparam int CLK_NS = 10;
    localparam int PW     = 17;
    localparam int MAXP   = 8;

    logic clk = 0, rst = 1, req = 0;
    logic [PW-1:0] req_page = '0;
    logic [10:0] req_col = '0;
    logic ready, rsp_valid, rsp_timeout, ecc_fatal, spi_cs_n, spi_sck, spi_mosi;
    logic [7:0] rsp_data;
    logic [1:0] ecc_code;
    logic spi_miso = 0;

    int checks = 0, errors = 0;

    nand_page_reader #(.PAGE_W(PW), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst(rst), .req(req), .req_page(req_page), .req_col(req_col),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_timeout(rsp_timeout), .ecc_code(ecc_code), .ecc_fatal(ecc_fatal),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [7:0] dpat(int p, int c);
        return 8'((p * 29) + (c * 7) + (c >> 8));
    endfunction

    // ---------------- device model ----------------
    int m_busy = 0, m_ecc = 0;
    int busy_left = 0, cur_ecc = 0, loaded = -1;
    int n_load = 0, n_poll = 0, n_read = 0, early = 0, bad = 0;
    int last_row = 0, last_col = 0, row_acc = 0, col_acc = 0;
    int bitn = 0, k = 0;
    logic [7:0] in_sr = 0, out_sr = 0, next_out = 0, op = 0;

    always @(negedge spi_cs_n) begin
        bitn = 0; k = 0; op = 0; row_acc = 0; col_acc = 0; next_out = 0;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        in_sr = {in_sr[6:0], spi_mosi};
        bitn++;
        if (bitn == 8) begin
            bitn = 0;
            next_out = 0;
            if (k == 0) op = in_sr;
            else case (op)
                8'h13: row_acc = (row_acc << 8) | int'(in_sr);
                8'h0F: if (k == 1) begin
                    if (in_sr != 8'hC0) bad++;
                    next_out = (busy_left > 0) ? 8'h01 : 8'((cur_ecc & 3) << 4);
                end
                8'h03: begin
                    if (k <= 2) col_acc = (col_acc << 8) | int'(in_sr);
                    if (k == 3) begin
                        if (busy_left > 0) early++;
                        next_out = dpat(loaded, col_acc);
                    end
                end
                default: bad++;
            endcase
            k++;
        end
    end

    always @(negedge spi_sck) if (!spi_cs_n) begin
        if (bitn == 0) begin
            spi_miso = next_out[7]; out_sr = {next_out[6:0], 1'b0};
        end else begin
            spi_miso = out_sr[7]; out_sr = {out_sr[6:0], 1'b0};
        end
    end

    always @(posedge spi_cs_n) begin
        if (op == 8'h13 && k == 4) begin
            loaded = row_acc; last_row = row_acc; busy_left = m_busy;
            cur_ecc = m_ecc; n_load++;
        end else if (op == 8'h0F && k == 3) begin
            n_poll++;
            if (busy_left > 0) busy_left--;
        end else if (op == 8'h03 && k == 5) begin
            n_read++; last_col = col_acc;
        end else if (op != 0) bad++;
        op = 0;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    logic [7:0] got;
    logic got_to;
    bit wd_hit = 0;

    task automatic do_read(input int p, input int c);
        @(negedge clk);
        req = 1; req_page = PW'(p); req_col = 11'(c);
        @(negedge clk);
        req = 0;
        for (int i = 0; i < 20000; i++) begin
            if (rsp_valid) begin got = rsp_data; got_to = rsp_timeout; return; end
            @(negedge clk);
        end
        wd_hit = 1;
        chk(0, "watchdog", 0, 1);
    endtask

    localparam int NV = 8;
    localparam int VP[NV] = '{5, 5, 5, 9, 9, 131071, 5, 5};
    localparam int VC[NV] = '{0, 2047, 291, 1024, 1, 2047, 16, 17};
    localparam int VB[NV] = '{2, 0, 0, 0, 0, 5, 1, 0};
    localparam int VE[NV] = '{0, 0, 0, 1, 0, 0, 0, 0};

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int exp_page, l0, p0, r0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(ready, "R1 ready", ready, 1);
        chk(spi_cs_n && !spi_sck, "R1 spi idle", {spi_cs_n, spi_sck}, 2);
        chk(!rsp_valid && ecc_code == 0 && !ecc_fatal, "R1 flags",
            {rsp_valid, ecc_code, ecc_fatal}, 0);

        exp_page = -1;
        for (int v = 0; v < NV; v++) begin
            bit miss;
            miss = (exp_page != VP[v]);
            m_busy = VB[v]; m_ecc = VE[v];
            l0 = n_load; p0 = n_poll; r0 = n_read;
            do_read(VP[v], VC[v]);
            if (wd_hit) break;
            chk(!got_to, "R5 no timeout", got_to, 0);
            chk(got == dpat(VP[v], VC[v]), "R5/R10 data", got, dpat(VP[v], VC[v]));
            chk(last_col == VC[v], "R5/R10 column", last_col, VC[v]);
            chk(n_read - r0 == 1, "R5 one cache read", n_read - r0, 1);
            if (miss) begin
                chk(n_load - l0 == 1, "R2/R7 load on miss", n_load - l0, 1);
                chk(last_row == VP[v], "R2 row address", last_row, VP[v]);
                chk(n_poll - p0 == VB[v] + 1, "R3 poll count", n_poll - p0, VB[v] + 1);
                chk(ecc_code == 2'(VE[v]), "R4 ecc code", ecc_code, VE[v]);
                exp_page = VP[v];
            end else begin
                chk(n_load == l0 && n_poll == p0, "R6 hit skips load",
                    n_load - l0 + n_poll - p0, 0);
            end
        end

        // R4 uncorrectable result: sticky, page still loaded
        m_busy = 0; m_ecc = 2;
        do_read(3, 100);
        chk(ecc_code == 2 && ecc_fatal, "R4 fatal set", {ecc_code, ecc_fatal}, 5);
        l0 = n_load;
        do_read(3, 101);
        chk(n_load == l0 && got == dpat(3, 101), "R4 page kept after fatal", n_load - l0, 0);
        m_ecc = 0;
        do_read(4, 7);
        chk(ecc_code == 0 && ecc_fatal, "R4 fatal sticky", {ecc_code, ecc_fatal}, 1);

        // R8 timeout then reload
        m_busy = 20;
        l0 = n_load; p0 = n_poll; r0 = n_read;
        do_read(7, 50);
        chk(got_to, "R8 timeout flag", got_to, 1);
        chk(n_poll - p0 == MAXP, "R8 poll limit", n_poll - p0, MAXP);
        chk(n_read == r0, "R8 no readout", n_read - r0, 0);
        m_busy = 0;
        l0 = n_load;
        do_read(7, 50);
        chk(n_load - l0 == 1 && !got_to && got == dpat(7, 50), "R8 reload after timeout",
            n_load - l0, 1);

        // R9 request while busy is ignored
        l0 = n_load; r0 = n_read;
        m_busy = 3;
        @(negedge clk);
        req = 1; req_page = PW'(10); req_col = 11'd5;
        @(negedge clk);
        req = 0;
        repeat (4) @(negedge clk);
        req = 1; req_page = PW'(11); req_col = 11'd6;
        @(negedge clk);
        req = 0;
        for (int i = 0; i < 20000 && !rsp_valid; i++) @(negedge clk);
        chk(rsp_data == dpat(10, 5) && last_row == 10, "R9 first request served",
            rsp_data, dpat(10, 5));
        repeat (300) @(negedge clk);
        chk(n_load - l0 == 1 && n_read - r0 == 1 && ready && spi_cs_n,
            "R9 busy request dropped", n_load - l0 + n_read - r0, 2);

        chk(early == 0, "R3 no read while busy", early, 0);
        chk(bad == 0, "R2/R3 frame format", bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule